// File: doc/BRIEF.md
# Character LCD Parallel Bus Controller

This block sits on the host side of a two-line, sixteen-column character display module that has an 8-bit parallel bus. It takes simple requests from a user port and turns each one into a bus write with correct timing. A request can be a raw instruction byte, a character code, or a cursor position given as a row and a column. The block drives the register-select, read/write and enable strobes and the eight data lines. The module latches a transfer on the falling edge of enable, so the bus must be stable before that edge.

Before every write, the controller reads the module's status and looks at bit 7, the busy flag. It repeats that read until the flag comes back clear. This removes the need for worst-case delays tied to how long each instruction takes to execute. After reset, the controller waits a programmable power-up interval. It then runs a fixed start-up sequence in this order: bus and line format, display on with no cursor, increment entry mode, clear. Only after that does it accept user requests.

The data bus is split into an output, an output-enable and an input, so the pad ring can build the bidirectional pins. The output-enable is low during every status read.

Top module: `lcd_bus_ctrl`

## Requirements
- R1: While reset is asserted and right after it, enable, data output-enable, `reqReady` and `initDone` are all low.
- R2: No enable pulse occurs until at least `POWERUP_CYC` clocks after reset is released.
- R3: The first four writes are instructions, with register-select 0 and read/write 0, in this order: 0x38, 0x0C, 0x06, 0x01. After the fourth write completes, `initDone` goes high.
- R4: Every write is preceded by a status read, with register-select 0 and read/write 1, whose bit 7 returned 0. While bit 7 returns 1, further status reads are made and no write happens.
- R5: An instruction request (`reqKind` = 0) writes `reqData` unchanged with register-select 0.
- R6: A character request (`reqKind` = 1) writes `reqData` with register-select 1.
- R7: A cursor request (`reqKind` = 2) writes, with register-select 0, the byte 0x80 | (row ? 0x40 : 0x00) | column, where the column is 0 to 15.
- R8: Enable stays high for exactly `PULSE_CYC` clocks. Register-select, read/write, data and output-enable are stable for at least `SETUP_CYC` clocks before enable rises and while it is high. They stay stable for `HOLD_CYC` clocks after it falls.
- R9: During a status read, the data output-enable is low.
- R10: `reqReady` is high only when the controller is idle after initialization. A request is taken only on a clock where both `reqValid` and `reqReady` are high. A `reqValid` while `reqReady` is low produces no bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A user request is presented |
| reqKind | input | 2 | 0 instruction, 1 character, 2 cursor position |
| reqData | input | 8 | Instruction or character byte |
| reqRow | input | 1 | Cursor row (0 top, 1 bottom) |
| reqCol | input | 4 | Cursor column 0 to 15 |
| reqReady | output | 1 | Controller can take a request this clock |
| initDone | output | 1 | Start-up sequence has completed |
| lcdRs | output | 1 | Register select: 1 data, 0 instruction or status |
| lcdRw | output | 1 | 1 status read, 0 write |
| lcdE | output | 1 | Enable strobe; module latches on its falling edge |
| lcdDataOut | output | 8 | Data driven toward the module |
| lcdDataOe | output | 1 | Drive enable for the data pads |
| lcdDataIn | input | 8 | Data read back from the module pads |

## Verification
The assertions assume three things about the block's inputs. `lcdDataIn` is valid at the clock where enable falls during a status read. `reqKind` never takes the value 3. `reqValid` is dropped on the clock after acceptance. The bench's bus responder meets these conditions. It updates its status byte only between clocks, and it holds the busy flag set for a random 0 to 3 polls after each write. The request driver draws kinds only from 0 to 2. Deliberate requests made while the controller is busy are held only during windows where `reqReady` is known to be low.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  localparam int COL_W  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    REQ_INSTR  = 2'd0,
    REQ_CHAR   = 2'd1,
    REQ_CURSOR = 2'd2
  } req_kind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic              start;
    logic              isRead;
    logic              rs;
    logic [BYTE_W-1:0] byteVal;
  } bus_strobe_t;

  // set-address opcode: bit7 set, bit6 selects the second line
  function automatic logic [BYTE_W-1:0] cursorCode(input logic row, input logic [COL_W-1:0] col);
    return {1'b1, row, 2'b00, col};
  endfunction

  function automatic logic [BYTE_W-1:0] initCmd(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h38;
      2'd1:    return 8'h0C;
      2'd2:    return 8'h06;
      default: return 8'h01;
    endcase
  endfunction

endpackage

// File: rtl/lcd_bus_dp.sv
module lcd_bus_dp
  import lcd_bus_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 50,
  parameter int unsigned PULSE_CYC = 50,
  parameter int unsigned HOLD_CYC  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_strobe_t       strb,
  input  logic [BYTE_W-1:0] dataIn,
  output logic              cycDone,
  output logic [BYTE_W-1:0] statusByte,
  output logic              lcdRs,
  output logic              lcdRw,
  output logic              lcdE,
  output logic [BYTE_W-1:0] lcdDataOut,
  output logic              lcdDataOe
);

  localparam int unsigned MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic              rsQ, rwQ, eQ, oeQ;
  logic [BYTE_W-1:0] dataQ, statQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      rsQ   <= 1'b0;
      rwQ   <= 1'b0;
      eQ    <= 1'b0;
      oeQ   <= 1'b0;
      dataQ <= '0;
      statQ <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (strb.start) begin
            rsQ   <= strb.rs;
            rwQ   <= strb.isRead;
            oeQ   <= !strb.isRead;
            if (!strb.isRead) dataQ <= strb.byteVal;
            cnt   <= CNT_W'(SETUP_CYC - 1);
            phase <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            eQ    <= 1'b1;
            cnt   <= CNT_W'(PULSE_CYC - 1);
            phase <= PH_PULSE;
          end else cnt <= cnt - 1'b1;
        end
        PH_PULSE: begin
          if (cnt == '0) begin
            eQ    <= 1'b0;
            if (rwQ) statQ <= dataIn;
            cnt   <= CNT_W'(HOLD_CYC - 1);
            phase <= PH_HOLD;
          end else cnt <= cnt - 1'b1;
        end
        default: begin
          if (cnt == '0) begin
            oeQ   <= 1'b0;
            phase <= PH_IDLE;
          end else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign cycDone    = (phase == PH_HOLD) && (cnt == '0);
  assign statusByte = statQ;
  assign lcdRs      = rsQ;
  assign lcdRw      = rwQ;
  assign lcdE       = eQ;
  assign lcdDataOut = dataQ;
  assign lcdDataOe  = oeQ;

  // enable-high length tracker for the pulse width check
  logic [CNT_W-1:0] eHighLen;
  always_ff @(posedge clk) begin
    if (!rst_n)   eHighLen <= '0;
    else if (eQ)  eHighLen <= eHighLen + 1'b1;
    else          eHighLen <= '0;
  end

  p_e_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcdE) |-> (eHighLen == CNT_W'(PULSE_CYC)));

  p_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lcdE && $past(lcdE)) |-> $stable({lcdRs, lcdRw, lcdDataOut, lcdDataOe}));

  p_hold_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcdE) |-> $stable({lcdRs, lcdRw, lcdDataOut, lcdDataOe}));

  p_read_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lcdE && lcdRw) |-> !lcdDataOe);

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_bus_pkg::*;
#(
  parameter int unsigned POWERUP_CYC = 1500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [BYTE_W-1:0] reqData,
  input  logic              reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              reqReady,
  output logic              initDone,
  input  logic              cycDone,
  input  logic [BYTE_W-1:0] statusByte,
  output bus_strobe_t       strb
);

  localparam int PWR_W = $clog2(POWERUP_CYC + 1);

  typedef enum logic [2:0] {
    ST_PWR, ST_POLL_GO, ST_POLL_WAIT, ST_WR_GO, ST_WR_WAIT, ST_IDLE
  } state_e;

  state_e            state;
  logic [PWR_W-1:0]  pwrCnt;
  logic [1:0]        initIdx;
  logic              initDoneQ;
  logic [BYTE_W-1:0] curByte;
  logic              curRs;
  logic              pollClear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_PWR;
      pwrCnt    <= '0;
      initIdx   <= 2'd0;
      initDoneQ <= 1'b0;
      curByte   <= '0;
      curRs     <= 1'b0;
      pollClear <= 1'b0;
    end else begin
      case (state)
        ST_PWR: begin
          if (pwrCnt == PWR_W'(POWERUP_CYC - 1)) begin
            curByte <= initCmd(2'd0);
            curRs   <= 1'b0;
            state   <= ST_POLL_GO;
          end else pwrCnt <= pwrCnt + 1'b1;
        end
        ST_POLL_GO: state <= ST_POLL_WAIT;
        ST_POLL_WAIT: begin
          if (cycDone) begin
            if (statusByte[7]) begin
              pollClear <= 1'b0;
              state     <= ST_POLL_GO;
            end else begin
              pollClear <= 1'b1;
              state     <= ST_WR_GO;
            end
          end
        end
        ST_WR_GO: begin
          pollClear <= 1'b0;
          state     <= ST_WR_WAIT;
        end
        ST_WR_WAIT: begin
          if (cycDone) begin
            if (initDoneQ) state <= ST_IDLE;
            else if (initIdx == 2'd3) begin
              initDoneQ <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              initIdx <= initIdx + 2'd1;
              curByte <= initCmd(initIdx + 2'd1);
              state   <= ST_POLL_GO;
            end
          end
        end
        default: begin
          if (reqValid) begin
            curRs   <= (reqKind == REQ_CHAR);
            curByte <= (reqKind == REQ_CURSOR) ? cursorCode(reqRow, reqCol) : reqData;
            state   <= ST_POLL_GO;
          end
        end
      endcase
    end
  end

  assign reqReady     = (state == ST_IDLE);
  assign initDone     = initDoneQ;
  assign strb.start   = (state == ST_POLL_GO) || (state == ST_WR_GO);
  assign strb.isRead  = (state == ST_POLL_GO);
  assign strb.rs      = (state == ST_POLL_GO) ? 1'b0 : curRs;
  assign strb.byteVal = curByte;

  p_write_after_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.start && !strb.isRead) |-> pollClear);

  p_ready_after_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> initDoneQ);

  p_init_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
    initDoneQ |-> (initIdx == 2'd3));

endmodule

// File: rtl/lcd_bus_ctrl.sv
module lcd_bus_ctrl
  import lcd_bus_pkg::*;
#(
  parameter int unsigned POWERUP_CYC = 1500000,
  parameter int unsigned SETUP_CYC   = 50,
  parameter int unsigned PULSE_CYC   = 50,
  parameter int unsigned HOLD_CYC    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [BYTE_W-1:0] reqData,
  input  logic              reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              reqReady,
  output logic              initDone,
  output logic              lcdRs,
  output logic              lcdRw,
  output logic              lcdE,
  output logic [BYTE_W-1:0] lcdDataOut,
  output logic              lcdDataOe,
  input  logic [BYTE_W-1:0] lcdDataIn
);

  bus_strobe_t       strb;
  logic              cycDone;
  logic [BYTE_W-1:0] statusByte;

  lcd_seq_ctrl #(.POWERUP_CYC(POWERUP_CYC)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqKind(reqKind), .reqData(reqData),
    .reqRow(reqRow), .reqCol(reqCol),
    .reqReady(reqReady), .initDone(initDone),
    .cycDone(cycDone), .statusByte(statusByte), .strb(strb)
  );

  lcd_bus_dp #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .dataIn(lcdDataIn),
    .cycDone(cycDone), .statusByte(statusByte),
    .lcdRs(lcdRs), .lcdRw(lcdRw), .lcdE(lcdE),
    .lcdDataOut(lcdDataOut), .lcdDataOe(lcdDataOe)
  );

endmodule

// File: tb/lcd_bus_ctrl_tb_top.sv
module lcd_bus_ctrl_tb_top;
  import lcd_bus_pkg::*;

  localparam int PWR = 300;
  localparam int SU  = 3;
  localparam int PW  = 4;
  localparam int HD  = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reqValid;
  logic [1:0] reqKind;
  logic [7:0] reqData;
  logic       reqRow;
  logic [3:0] reqCol;
  logic       reqReady, initDone;
  logic       lcdRs, lcdRw, lcdE, lcdDataOe;
  logic [7:0] lcdDataOut;
  logic [7:0] lcdDataIn;

  lcd_bus_ctrl #(.POWERUP_CYC(PWR), .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind), .reqData(reqData),
    .reqRow(reqRow), .reqCol(reqCol), .reqReady(reqReady), .initDone(initDone),
    .lcdRs(lcdRs), .lcdRw(lcdRw), .lcdE(lcdE), .lcdDataOut(lcdDataOut),
    .lcdDataOe(lcdDataOe), .lcdDataIn(lcdDataIn)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // expected write stream
  logic [7:0] expByte [0:255];
  logic       expRsA  [0:255];
  string      expTag  [0:255];
  int expN = 0;
  int wrN  = 0;

  function automatic logic [7:0] expCursor(input logic r, input logic [3:0] c);
    return 8'h80 + (r ? 8'h40 : 8'h00) + {4'h0, c};
  endfunction

  task automatic pushExp(input logic [7:0] b, input logic rs, input string tag);
    expByte[expN] = b;
    expRsA[expN]  = rs;
    expTag[expN]  = tag;
    expN++;
  endtask

  // behavioural bus responder and monitor
  int cyc = 0;
  int busyLeft = 2;
  bit lastClear = 0;
  bit prevE = 0;
  bit sawRise = 0;
  int eLen = 0;
  int stableCnt = 0;
  logic [10:0] prevBus = '0;
  logic [10:0] holdBus = '0;
  int holdLeft = 0;
  bit holdOk = 1;

  always @(negedge clk) begin
    logic [10:0] busNow;
    busNow = {lcdRs, lcdRw, lcdDataOut, lcdDataOe};
    if (!rst_n) begin
      lcdDataIn <= {1'b1, 7'h15};
      cyc = 0;
    end else begin
      cyc++;
      if (lcdE && !prevE) begin
        if (!sawRise) begin
          check(cyc >= PWR, "R2 first enable after power-up wait", cyc, PWR);
          sawRise = 1;
        end
        check(stableCnt >= SU && busNow == prevBus, "R8 setup before enable", stableCnt, SU);
      end
      if (lcdE) eLen++;
      if (!lcdE && prevE) begin
        check(eLen == PW, "R8 enable width", eLen, PW);
        eLen = 0;
        if (lcdRw) begin
          check(!lcdDataOe && !lcdRs, "R9 status read floats bus", {lcdRs, lcdDataOe}, 0);
          lastClear = (busyLeft == 0);
          if (busyLeft > 0) busyLeft--;
        end else begin
          check(lastClear, "R4 write after clear poll", lastClear, 1);
          lastClear = 0;
          if (wrN < expN)
            check(lcdDataOut == expByte[wrN] && lcdRs == expRsA[wrN], expTag[wrN],
                  {lcdRs, lcdDataOut}, {expRsA[wrN], expByte[wrN]});
          else
            check(0, "R10 unexpected write", lcdDataOut, 0);
          wrN++;
          busyLeft = $urandom_range(0, 3);
          holdLeft = HD - 1;
          holdBus  = busNow;
          holdOk   = 1;
          if (holdLeft == 0) check(1, "R8 hold", 0, 0);
        end
        lcdDataIn <= {(busyLeft != 0), 7'h15};
      end else if (holdLeft > 0) begin
        if (busNow != holdBus) holdOk = 0;
        holdLeft--;
        if (holdLeft == 0) check(holdOk, "R8 hold after enable", busNow, holdBus);
      end
      if (busNow == prevBus && !lcdE) stableCnt++;
      else stableCnt = 1;
      prevBus = busNow;
      prevE = lcdE;
    end
  end

  task automatic send(input logic [1:0] k, input logic [7:0] d, input logic r,
                      input logic [3:0] c, input logic [7:0] eb, input logic ers,
                      input string tag, input bit bogus);
    pushExp(eb, ers, tag);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqData = d; reqRow = r; reqCol = c;
    @(negedge clk);
    reqValid = 1'b0;
    if (bogus) begin
      reqValid = 1'b1; reqKind = 2'd1; reqData = 8'hEE;
      for (int i = 0; i < 3; i++) begin
        check(!reqReady, "R10 ready low while busy", reqReady, 0);
        @(negedge clk);
      end
      reqValid = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    rst_n = 1'b0; reqValid = 1'b0; reqKind = 2'd0; reqData = 8'h00; reqRow = 1'b0; reqCol = 4'h0;
    repeat (3) @(negedge clk);
    check(!lcdE && !lcdDataOe, "R1 bus idle in reset", {lcdE, lcdDataOe}, 0);
    check(!reqReady && !initDone, "R1 handshake low in reset", {reqReady, initDone}, 0);
    pushExp(8'h38, 1'b0, "R3 init step 1");
    pushExp(8'h0C, 1'b0, "R3 init step 2");
    pushExp(8'h06, 1'b0, "R3 init step 3");
    pushExp(8'h01, 1'b0, "R3 init step 4");
    rst_n = 1'b1;
    @(negedge clk);
    check(!lcdE && !reqReady && !initDone, "R1 state after reset", {lcdE, reqReady, initDone}, 0);
    while (!initDone) @(negedge clk);
    check(wrN == 4, "R3 init done after four writes", wrN, 4);

    send(2'd2, 8'h00, 1'b1, 4'd15, expCursor(1'b1, 4'd15), 1'b0, "R7 cursor row1 col15", 1'b1);
    send(2'd2, 8'h00, 1'b0, 4'd0,  expCursor(1'b0, 4'd0),  1'b0, "R7 cursor row0 col0", 1'b0);
    send(2'd1, 8'h41, 1'b0, 4'd0,  8'h41, 1'b1, "R6 character write", 1'b1);
    send(2'd0, 8'h0C, 1'b0, 4'd0,  8'h0C, 1'b0, "R5 instruction write", 1'b0);
    send(2'd2, 8'hFF, 1'b1, 4'd0,  expCursor(1'b1, 4'd0),  1'b0, "R7 cursor ignores data", 1'b0);

    for (int n = 0; n < 30; n++) begin
      logic [1:0] k;
      logic [7:0] d;
      logic       r;
      logic [3:0] c;
      k = 2'($urandom_range(0, 2));
      d = 8'($urandom);
      r = 1'($urandom);
      c = 4'($urandom);
      case (k)
        2'd0:    send(k, d, r, c, d, 1'b0, "R5 random instruction", n[2]);
        2'd1:    send(k, d, r, c, d, 1'b1, "R6 random character", n[2]);
        default: send(k, d, r, c, expCursor(r, c), 1'b0, "R7 random cursor", n[2]);
      endcase
    end

    while (!(reqReady && wrN >= expN)) @(negedge clk);
    repeat (20) @(negedge clk);
    check(wrN == expN, "R10 no extra writes", wrN, expN);
    finishRun();
  end

endmodule